// File: doc/BRIEF.md
# Low-Speed Oscillator Enable and Ready Gating

This block governs one low-speed clock source. A software enable starts the source, and a startup counter then counts edges of the raw oscillator clock. After a programmable number of edges, hardware raises a ready flag, and the block then releases the raw clock on its gated output. No glitch or partial pulse leaves the block while the source is still settling.

A bypass selection covers the case where an external clock drives the raw input instead of a crystal. This external clock runs at 1 MHz or less. Bypass takes effect only while the enable is also set, and it replaces the programmed settle count with a short fixed one. The ready flag is carried into the register clock domain through two flip-flops. A rising ready flag can latch an interrupt that stays pending until software clears it.

Top module: `osc_ready_gate`

## Requirements
- R1: While rst_ni is low, and immediately after it rises, clk_o, rdy_o, irq_o and byp_mode_o are all 0.
- R2: rdy_o is set only by the startup counter. It is still 0 when sampled just after raw edge L+2, counted from the rise of en_i, where L is the effective settle count. It is 1 by the time clk_o first rises. It never rises while en_i is low.
- R3: In crystal mode (byp_i = 0), the first rising edge of clk_o coincides with raw rising edge L+3 after en_i rises. L equals settle_cnt_i, with a value of 0 treated as 1.
- R4: clk_o has no rising edge before it is released. Once it is released, it follows every rising edge of osc_clk_i.
- R5: When both byp_i and en_i are 1, L equals the parameter BYP_CNT (default 4) and settle_cnt_i is ignored. byp_mode_o equals en_i AND byp_i, registered once on clk_i. byp_i alone produces no clock, no ready flag and no mode indication.
- R6: When rdy_o rises, irq_o is set one clk_i cycle later if rdy_ie_i is 1. irq_o is not set if rdy_ie_i is 0.
- R7: irq_o stays set until irq_clr_i is sampled as 1 on a clk_i edge. It is cleared on that edge.
- R8: After en_i falls, clk_o shows at most two further rising edges, on the first two raw rising edges, and then stays low. rdy_o returns to 0 within three raw periods.
- R9: Each rise of en_i restarts the startup count from zero. This holds even if an earlier enable was dropped part-way through the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| osc_clk_i | input | 1 | Raw oscillator or external bypass clock |
| en_i | input | 1 | Software enable for the source |
| byp_i | input | 1 | Bypass selection, effective only with en_i |
| settle_cnt_i | input | CNT_W | Crystal-mode settle count in raw edges; hold stable while enabled |
| rdy_ie_i | input | 1 | Ready interrupt enable |
| irq_clr_i | input | 1 | Write-one clear of the pending ready interrupt |
| clk_o | output | 1 | Gated oscillator clock |
| rdy_o | output | 1 | Ready flag, synchronised to clk_i |
| byp_mode_o | output | 1 | Bypass mode active |
| irq_o | output | 1 | Pending ready interrupt |

## Verification
The bench sweeps the crystal settle count from 0 to 9 and checks the exact raw edge at which the clock is released. This separates an off-by-one in the counter, the synchroniser depth and the gate timing, and it exposes a count of 0 that is not promoted to 1. Bypass runs use a large settle count, which shows whether the fixed bypass count really replaces it. A bypass bit set without the enable shows whether bypass is wrongly decoded on its own. Disabling the source after release and part-way through settling separates the release boundary from a counter that fails to restart. The interrupt enable alternates across the sweep, so pending with the enable off, loss of the held state and clear priority each show up as a distinct mismatch.

// File: rtl/osc_gate_pkg.sv
package osc_gate_pkg;

  // settle count of zero is promoted to one edge
  function automatic logic [31:0] eff_limit(input logic [31:0] lim);
    return (lim == 32'd0) ? 32'd1 : lim;
  endfunction

endpackage

// File: rtl/osc_sync.sv
module osc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/osc_startup_ctr.sv
module osc_startup_ctr
  import osc_gate_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int BYP_CNT = 4
) (
  input  logic             osc_clk_i,
  input  logic             rst_ni,
  input  logic             en_s_i,
  input  logic             byp_s_i,
  input  logic [CNT_W-1:0] settle_cnt_i,
  output logic             rdy_o
);

  localparam logic [CNT_W:0] BYP_LIM = (CNT_W+1)'(eff_limit(32'(BYP_CNT)));

  logic [CNT_W-1:0] cnt_q;
  logic             rdy_q;
  logic [CNT_W:0]   lim;
  logic [CNT_W:0]   cnt_nxt;

  always_comb begin
    lim     = byp_s_i ? BYP_LIM : (CNT_W+1)'(eff_limit(32'(settle_cnt_i)));
    cnt_nxt = {1'b0, cnt_q} + 1'b1;
  end

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!en_s_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      cnt_q <= cnt_nxt[CNT_W-1:0];
      if (cnt_nxt >= lim) rdy_q <= 1'b1;
    end
  end

  // masked at once when the synchronised enable drops
  assign rdy_o = rdy_q & en_s_i;

  assert_rdy_after_en_R2: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    rdy_q |-> $past(en_s_i));

  assert_cnt_restart_R9: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $past(en_s_i));

endmodule

// File: rtl/osc_clk_gate.sv
module osc_clk_gate (
  input  logic osc_clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  output logic clk_o
);

  logic gate_q;

  // enable changes only while the raw clock is low
  always_ff @(negedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= rdy_i;
  end

  assign clk_o = osc_clk_i & gate_q;

  assert_gate_from_rdy_R4: assert property (@(negedge osc_clk_i) disable iff (!rst_ni)
    gate_q |-> $past(rdy_i));

endmodule

// File: rtl/osc_rdy_irq.sv
module osc_rdy_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  input  logic ie_i,
  input  logic clr_i,
  output logic irq_o
);

  logic rdy_d_q;
  logic pend_q;
  logic rise;

  assign rise = rdy_i & ~rdy_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_d_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      rdy_d_q <= rdy_i;
      if (rise && ie_i) pend_q <= 1'b1;
      else if (clr_i)   pend_q <= 1'b0;
    end
  end

  assign irq_o = pend_q;

  assert_irq_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(rdy_i && ie_i));

  assert_irq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);

endmodule

// File: rtl/osc_ready_gate.sv
module osc_ready_gate #(
  parameter int CNT_W       = 12,
  parameter int BYP_CNT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_clk_i,
  input  logic             en_i,
  input  logic             byp_i,
  input  logic [CNT_W-1:0] settle_cnt_i,
  input  logic             rdy_ie_i,
  input  logic             irq_clr_i,
  output logic             clk_o,
  output logic             rdy_o,
  output logic             byp_mode_o,
  output logic             irq_o
);

  logic [1:0] ctl_s;
  logic       rdy_osc;
  logic       byp_mode_q;

  osc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk_i (osc_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({byp_i & en_i, en_i}),
    .q_o   (ctl_s)
  );

  osc_startup_ctr #(.CNT_W(CNT_W), .BYP_CNT(BYP_CNT)) u_ctr (
    .osc_clk_i   (osc_clk_i),
    .rst_ni      (rst_ni),
    .en_s_i      (ctl_s[0]),
    .byp_s_i     (ctl_s[1]),
    .settle_cnt_i(settle_cnt_i),
    .rdy_o       (rdy_osc)
  );

  osc_clk_gate u_gate (
    .osc_clk_i(osc_clk_i),
    .rst_ni   (rst_ni),
    .rdy_i    (rdy_osc),
    .clk_o    (clk_o)
  );

  osc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rdy_osc),
    .q_o   (rdy_o)
  );

  osc_rdy_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rdy_i (rdy_o),
    .ie_i  (rdy_ie_i),
    .clr_i (irq_clr_i),
    .irq_o (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_mode_q <= 1'b0;
    else         byp_mode_q <= en_i & byp_i;
  end

  assign byp_mode_o = byp_mode_q;

  assert_byp_needs_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_mode_o |-> $past(en_i && byp_i));

endmodule

// File: tb/osc_ready_gate_tb.sv
module osc_ready_gate_tb_top;

  localparam int CNT_W   = 12;
  localparam int BYP_CNT = 4;

  logic             clk_i = 1'b0;
  logic             osc_clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic             byp_i = 1'b0;
  logic [CNT_W-1:0] settle_cnt_i = '0;
  logic             rdy_ie_i = 1'b0;
  logic             irq_clr_i = 1'b0;
  logic             clk_o, rdy_o, byp_mode_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int edge_cnt = 0;
  bit done = 1'b0;

  always #4  clk_i = ~clk_i;
  always #21 osc_clk_i = ~osc_clk_i;
  always @(posedge clk_o) edge_cnt++;

  osc_ready_gate #(.CNT_W(CNT_W), .BYP_CNT(BYP_CNT)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_clk_i(osc_clk_i), .en_i(en_i),
    .byp_i(byp_i), .settle_cnt_i(settle_cnt_i), .rdy_ie_i(rdy_ie_i),
    .irq_clr_i(irq_clr_i), .clk_o(clk_o), .rdy_o(rdy_o),
    .byp_mode_o(byp_mode_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_irq();
    @(negedge clk_i); irq_clr_i = 1'b1;
    @(negedge clk_i); irq_clr_i = 1'b0;
    #1;
  endtask

  // enable the source and measure the release edge
  task automatic start_run(input int lim, input bit byp, input bit ie, input int exp_l);
    int n = 0;
    int first = 0;
    settle_cnt_i = CNT_W'(lim);
    byp_i = byp;
    rdy_ie_i = ie;
    @(negedge osc_clk_i); #5;
    en_i = 1'b1;
    edge_cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge osc_clk_i); #1;
      n++;
      if (n == exp_l + 2) chk("R2 rdy low before settle", int'(rdy_o), 0);
      if (clk_o) begin
        first = n;
        break;
      end
    end
    chk("R3 release edge", first, exp_l + 3);
    chk("R4 no early pulse", edge_cnt, 1);
    chk("R2 rdy at release", int'(rdy_o), 1);
    chk("R5 mode flag", int'(byp_mode_o), int'(byp));
    repeat (4) @(posedge osc_clk_i);
    #1;
    chk("R4 follows raw", edge_cnt, 5);
    chk("R6 irq after ready", int'(irq_o), int'(ie));
    if (ie) begin
      repeat (10) @(negedge clk_i);
      chk("R7 irq held", int'(irq_o), 1);
      clear_irq();
      chk("R7 irq cleared", int'(irq_o), 0);
    end
  endtask

  task automatic stop_run();
    @(negedge osc_clk_i); #5;
    en_i = 1'b0;
    edge_cnt = 0;
    repeat (3) @(posedge osc_clk_i);
    #2;
    chk("R8 rdy drops", int'(rdy_o), 0);
    repeat (3) @(posedge osc_clk_i);
    #1;
    chk("R8 tail edges", edge_cnt, 2);
    byp_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #30;
    chk("R1 clk_o in reset", int'(clk_o), 0);
    chk("R1 rdy_o in reset", int'(rdy_o), 0);
    #13 rst_ni = 1'b1;
    #1;
    chk("R1 irq_o after reset", int'(irq_o), 0);
    chk("R1 mode after reset", int'(byp_mode_o), 0);

    // crystal sweep, interrupt enable alternating
    for (int l = 0; l < 10; l++) begin
      start_run(l, 1'b0, l[0], (l == 0) ? 1 : l);
      stop_run();
    end

    // bypass ignores the programmed count
    start_run(9, 1'b1, 1'b1, BYP_CNT);
    stop_run();
    start_run(0, 1'b1, 1'b0, BYP_CNT);
    stop_run();

    // bypass bit alone does nothing
    byp_i = 1'b1;
    edge_cnt = 0;
    repeat (20) @(posedge osc_clk_i);
    #1;
    chk("R5 byp alone clk", edge_cnt, 0);
    chk("R5 byp alone rdy", int'(rdy_o), 0);
    chk("R5 byp alone mode", int'(byp_mode_o), 0);
    chk("R2 no rdy while off", int'(irq_o), 0);
    byp_i = 1'b0;

    // partial settle then restart from zero
    settle_cnt_i = CNT_W'(6);
    @(negedge osc_clk_i); #5;
    en_i = 1'b1;
    repeat (6) @(posedge osc_clk_i);
    @(negedge osc_clk_i); #5;
    en_i = 1'b0;
    repeat (4) @(posedge osc_clk_i);
    #1;
    chk("R9 partial no rdy", int'(rdy_o), 0);
    start_run(6, 1'b0, 1'b0, 6);
    stop_run();
    start_run(6, 1'b0, 1'b1, 6);
    stop_run();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule